// File: doc/BRIEF.md
# Interleaved lane exclusive-or unit

This block is a vector datapath that combines two source vectors lane by lane with exclusive-or. Elements are taken in adjacent pairs. One element of each pair in the first source is combined with the element of the opposite parity in the same pair of the second source. The result goes into only one parity of destination lanes. Lanes of the other parity pass the destination input through unchanged, so the block can update one half of a register while keeping the other half.

A 32-bit instruction word is decoded inside the block. The decoder supplies:

- the element size (8, 16, 32 or 64 bits);
- the mode bit, which selects which parity is written;
- the three register numbers.

When the word does not match the instruction pattern, no result is produced. An accepted strobe is captured and presented one clock later. The vector width is a parameter and must be a multiple of 128 bits.

Top module: `ilx_unit`

## Requirements
- R1: `hit_o` is 1 exactly when `instr_i[31:24]` = 8'b01000101, `instr_i[21]` = 0 and `instr_i[15:11]` = 5'b10010. Any other word gives 0.
- R2: The register numbers are taken from the instruction word: `rm_o` = bits 20:16, `rn_o` = bits 9:5 and `rd_o` = bits 4:0.
- R3: The size field `instr_i[23:22]` selects the element width: 00 is 8 bits, 01 is 16 bits, 10 is 32 bits and 11 is 64 bits.
- R4: When `instr_i[10]` = 0 (bottom-top), each even result element equals the even element of `src_a_i` XOR the odd element of `src_b_i` in the same pair.
- R5: When `instr_i[10]` = 1 (top-bottom), each odd result element equals the odd element of `src_a_i` XOR the even element of `src_b_i` in the same pair.
- R6: Result elements of the parity that is not written equal the corresponding elements of `dst_i`.
- R7: Element 0 occupies the least-significant bits, and element k occupies bits [k*E +: E], where E is the element width.
- R8: When `valid_i` and `hit_o` are both 1 at a clock edge, `res_o` and `res_valid_o` = 1 appear after exactly that edge.
- R9: When `valid_i` is 1 and `hit_o` is 0, `res_valid_o` is 0 in the next cycle.
- R10: A synchronous active-high `rst` drives `res_valid_o` to 0.
- R11: `res_o` keeps its value at every edge that does not accept a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operand strobe |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | VEC_W | First source vector |
| src_b_i | input | VEC_W | Second source vector |
| dst_i | input | VEC_W | Prior destination value |
| hit_o | output | 1 | Instruction word matches (combinational) |
| rd_o | output | 5 | Destination register number |
| rn_o | output | 5 | First source register number |
| rm_o | output | 5 | Second source register number |
| res_o | output | VEC_W | Registered result vector |
| res_valid_o | output | 1 | Result valid, one cycle after an accepted strobe |

## Verification
The hardest case to reach is an element whose written and kept lanes differ in a way that exposes a wrong pair partner or a wrong parity at a given size. To reach it, every size and mode combination is run with random vectors and with sparse one-hot patterns. Each result is compared against a bit-by-bit reference model. Every fixed opcode bit is also flipped one at a time, with the strobe held high, to show that a near-miss word produces no valid result.

// File: rtl/ilx_pkg.sv
package ilx_pkg;
    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } elem_sz_e;

    typedef enum logic {
        MODE_BT = 1'b0,
        MODE_TB = 1'b1
    } pair_mode_e;

    localparam logic [7:0] OPC_HIGH = 8'b0100_0101;
    localparam logic [4:0] OPC_MID  = 5'b10010;
endpackage

// File: rtl/ilx_decode.sv
module ilx_decode
    import ilx_pkg::*;
(
    input  logic [31:0] instr_i,
    output logic        hit_o,
    output elem_sz_e    size_o,
    output pair_mode_e  mode_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  rn_o,
    output logic [4:0]  rm_o
);
    always_comb begin
        hit_o  = (instr_i[31:24] == OPC_HIGH) && !instr_i[21]
                 && (instr_i[15:11] == OPC_MID);
        size_o = elem_sz_e'(instr_i[23:22]);
        mode_o = pair_mode_e'(instr_i[10]);
        rm_o   = instr_i[20:16];
        rn_o   = instr_i[9:5];
        rd_o   = instr_i[4:0];
    end
endmodule

// File: rtl/ilx_lane_xor.sv
module ilx_lane_xor #(
    parameter int VEC_W  = 256,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic [VEC_W-1:0] d_i,
    input  logic             mode_i,
    output logic [VEC_W-1:0] r_o
);
    localparam int PAIR_W  = 2 * ELEM_W;
    localparam int N_PAIRS = VEC_W / PAIR_W;

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        localparam int EV = p * PAIR_W;
        localparam int OD = p * PAIR_W + ELEM_W;
        always_comb begin
            if (mode_i) begin
                r_o[EV +: ELEM_W] = d_i[EV +: ELEM_W];
                r_o[OD +: ELEM_W] = a_i[OD +: ELEM_W] ^ b_i[EV +: ELEM_W];
            end else begin
                r_o[EV +: ELEM_W] = a_i[EV +: ELEM_W] ^ b_i[OD +: ELEM_W];
                r_o[OD +: ELEM_W] = d_i[OD +: ELEM_W];
            end
        end
    end
endmodule

// File: rtl/ilx_unit.sv
module ilx_unit
    import ilx_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [31:0]      instr_i,
    input  logic [VEC_W-1:0] src_a_i,
    input  logic [VEC_W-1:0] src_b_i,
    input  logic [VEC_W-1:0] dst_i,
    output logic             hit_o,
    output logic [4:0]       rd_o,
    output logic [4:0]       rn_o,
    output logic [4:0]       rm_o,
    output logic [VEC_W-1:0] res_o,
    output logic             res_valid_o
);
    localparam int N_SIZES = 4;

    if (VEC_W % 128 != 0) begin : g_bad_width
        $error("VEC_W must be a multiple of 128");
    end

    elem_sz_e   size;
    pair_mode_e mode;
    logic [VEC_W-1:0] per_size [N_SIZES];
    logic [VEC_W-1:0] res_d;
    logic             accept;

    ilx_decode u_dec (
        .instr_i (instr_i),
        .hit_o   (hit_o),
        .size_o  (size),
        .mode_o  (mode),
        .rd_o    (rd_o),
        .rn_o    (rn_o),
        .rm_o    (rm_o)
    );

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        ilx_lane_xor #(.VEC_W(VEC_W), .ELEM_W(8 << s)) u_lane (
            .a_i    (src_a_i),
            .b_i    (src_b_i),
            .d_i    (dst_i),
            .mode_i (mode == MODE_TB),
            .r_o    (per_size[s])
        );
    end

    always_comb begin
        unique case (size)
            SZ_8:    res_d = per_size[0];
            SZ_16:   res_d = per_size[1];
            SZ_32:   res_d = per_size[2];
            default: res_d = per_size[3];
        endcase
        accept = valid_i && hit_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o <= 1'b0;
            res_o       <= '0;
        end else begin
            res_valid_o <= accept;
            if (accept) res_o <= res_d;
        end
    end

    // R8
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && hit_o) |=> res_valid_o);

    // R9
    miss_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_o |=> !res_valid_o);

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && hit_o) |=> $stable(res_o));

    // R8
    valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(valid_i));
endmodule

// File: tb/ilx_unit_test.sv
module ilx_unit_test;
    localparam int W = 256;

    logic clk = 1'b0;
    logic rst, valid_i;
    logic [31:0] instr_i;
    logic [W-1:0] a, b, d;
    logic hit_o, res_valid_o;
    logic [4:0] rd_o, rn_o, rm_o;
    logic [W-1:0] res_o;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    ilx_unit #(.VEC_W(W)) uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .src_a_i(a), .src_b_i(b), .dst_i(d), .hit_o(hit_o),
        .rd_o(rd_o), .rn_o(rn_o), .rm_o(rm_o), .res_o(res_o),
        .res_valid_o(res_valid_o)
    );

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic md,
                                       input logic [4:0] rm, input logic [4:0] rn,
                                       input logic [4:0] rd);
        return {8'b01000101, sz, 1'b0, rm, 5'b10010, md, rn, rd};
    endfunction

    function automatic logic [W-1:0] ref_model(input logic [1:0] sz, input logic md,
                                              input logic [W-1:0] ra, input logic [W-1:0] rb,
                                              input logic [W-1:0] rdst);
        logic [W-1:0] r;
        int e;
        e = 8 << sz;
        for (int i = 0; i < W; i++) begin
            int lane, off;
            lane = i / e;
            off  = i % e;
            if ((lane % 2) == int'(md)) r[i] = ra[i] ^ rb[(lane ^ 1) * e + off];
            else                        r[i] = rdst[i];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd();
        logic [W-1:0] v;
        for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic md, input string req);
        logic [W-1:0] exp;
        @(negedge clk);
        instr_i = mk(sz, md, 5'd3, 5'd7, 5'd12);
        valid_i = 1'b1;
        exp = ref_model(sz, md, a, b, d);
        @(negedge clk);
        valid_i = 1'b0;
        chk({req, " R8 valid"}, W'(res_valid_o), W'(1));
        chk(req, res_o, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        rst = 1'b1; valid_i = 1'b1; instr_i = mk(2'b00, 1'b0, 0, 0, 0);
        a = '0; b = '0; d = '0;
        repeat (3) @(negedge clk);
        // R10: reset holds valid low even with an accepted strobe
        chk("R10 reset", W'(res_valid_o), W'(0));
        rst = 1'b0; valid_i = 1'b0;

        // R1 R2 decode
        instr_i = mk(2'b10, 1'b1, 5'd17, 5'd9, 5'd30);
        #1;
        chk("R1 hit", W'(hit_o), W'(1));
        chk("R2 fields", W'({rm_o, rn_o, rd_o}), W'({5'd17, 5'd9, 5'd30}));

        // R1 R9: flip each fixed bit one at a time
        foreach (instr_i[k]) begin
            if (k >= 24 || k == 21 || (k >= 11 && k <= 15)) begin
                @(negedge clk);
                instr_i = mk(2'b01, 1'b0, 0, 0, 0) ^ (32'd1 << k);
                valid_i = 1'b1;
                #1;
                chk("R1 near miss", W'(hit_o), W'(0));
                @(negedge clk);
                valid_i = 1'b0;
                chk("R9 no valid", W'(res_valid_o), W'(0));
            end
        end

        // R3 R4 R5 R6 R7: sweep sizes and modes with random vectors
        for (int sz = 0; sz < 4; sz++) begin
            for (int md = 0; md < 2; md++) begin
                for (int n = 0; n < 6; n++) begin
                    a = rnd(); b = rnd(); d = rnd();
                    run_op(2'(sz), 1'(md), md ? "R5 R3 R6 random" : "R4 R3 R6 random");
                end
                // R7: one-hot patterns locate element boundaries
                for (int bit_i = 0; bit_i < W; bit_i += 37) begin
                    a = '0; b = W'(1) << bit_i; d = '0;
                    run_op(2'(sz), 1'(md), "R7 onehot b");
                    a = W'(1) << bit_i; b = '0; d = ~'0;
                    run_op(2'(sz), 1'(md), "R6 R7 onehot a");
                end
            end
        end

        // R11: result holds when no strobe, and for a strobe with a miss
        held = res_o;
        @(negedge clk);
        a = rnd(); b = rnd(); d = rnd();
        valid_i = 1'b0;
        @(negedge clk);
        chk("R11 idle hold", res_o, held);
        instr_i = 32'h0; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R11 miss hold", res_o, held);
        chk("R8 back low", W'(res_valid_o), W'(0));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule